// File: doc/BRIEF.md
# Multiplexed Byte-Wide External Memory Controller

This block sits between a core that works with 16-bit instruction words and a single byte-wide external memory. The low address byte and the 8-bit data share one group of pins. The core asks for an instruction fetch or a table write. The controller then runs a fixed pin sequence. First it puts the address on the shared byte and raises ALE, so that an external transparent latch can hold it. Next it turns the shared byte around. For a fetch it reads two bytes back to back, with the byte-select line BA0 at 0 and then at 1. It joins the two bytes into one 16-bit word and pulses done.

A table write drives one data byte onto the shared pins while the write strobe WRL is low. BA0 follows bit 0 of the requested address. The upper address byte and the top address nibble are driven according to a per-request address-width selection. The chip-enable line covers every access and is forced inactive while the sleep input is high.

Each byte phase lasts `BYTE_TICKS` clocks (default 2). This lets the memory's access time be met. All pin outputs come straight from registers.

Top module: `xmem_mux8_ctrl`

## Requirements
- R1: While reset is high and on the first clock after it, ALE and ad_oe_o are 0, and oe_n_o, wrl_n_o and ce_n_o are 1. done_o is 0.
- R2: An accepted request starts with an address phase of exactly BYTE_TICKS clocks. In it ALE is 1, ad_oe_o is 1 and ad_o carries address bits 7:0.
- R3: A fetch holds oe_n_o low for 2*BYTE_TICKS clocks. BA0 is 0 for the first BYTE_TICKS of those clocks and 1 for the rest. rdata_o = {byte read with BA0=1, byte read with BA0=0}. done_o is high for one clock only, 3*BYTE_TICKS+2 clocks after the accepting edge.
- R4: In a fetch, exactly one clock with ALE low, oe_n_o high and ad_oe_o low separates the address phase from the first read phase. ad_oe_o is never 1 while oe_n_o is 0.
- R5: A table write drives wrl_n_o low for BYTE_TICKS clocks. In those clocks ad_oe_o is 1, ad_o holds the write byte and BA0 equals bit 0 of the request address. done_o rises 2*BYTE_TICKS+1 clocks after the accepting edge.
- R6: wrl_n_o stays high during fetches and oe_n_o stays high during table writes.
- R7: ce_n_o is 0 on every clock from the first address clock up to the done clock, and it is 1 on the done clock.
- R8: width_i selects the address width: 0 = 8-bit, 1 = 12-bit, 2 = 16-bit, 3 = 20-bit. ahi_oe_o (address bits 15:8) is 1 during the access for every code except 0. aup_oe_o (address bits 19:16) is 1 only for code 3. Lines that are not driven output 0.
- R9: While sleep_i is high, no request is accepted. From the next clock on, ALE is 0 and oe_n_o, wrl_n_o and ce_n_o are 1. A request held through sleep starts its normal sequence on the clock after sleep is released.
- R10: Sleep during an access freezes the sequence with all strobes inactive. After release, the interrupted phase restarts in full and the access completes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request, held high until done_o |
| req_wr_i | input | 1 | 1 = table write, 0 = instruction fetch |
| req_addr_i | input | 20 | Byte address of the access |
| req_wdata_i | input | 8 | Byte to write |
| width_i | input | 2 | Address width code (R8) |
| sleep_i | input | 1 | Sleep request |
| rdata_o | output | 16 | Assembled fetch word |
| done_o | output | 1 | One-clock completion pulse |
| ad_o | output | 8 | Shared address/data byte, out |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ad_i | input | 8 | Shared address/data byte, in |
| ahi_o | output | 8 | Address bits 15:8 |
| ahi_oe_o | output | 1 | Drive enable for ahi_o |
| aup_o | output | 4 | Address bits 19:16 |
| aup_oe_o | output | 1 | Drive enable for aup_o |
| ale_o | output | 1 | Address latch enable |
| oe_n_o | output | 1 | Output enable, active low |
| wrl_n_o | output | 1 | Write strobe, active low |
| ce_n_o | output | 1 | Chip enable, active low |
| ba0_o | output | 1 | Byte select, address bit 0 |

## Verification
The bench models an external transparent latch and a memory whose content depends on every address bit, including BA0. If the byte order were swapped, or BA0 were not toggled, the assembled word would be wrong. If the upper address lines were left undriven, the wrong location would be read. The bench counts strobe clocks per access. This catches a phase that is too long or too short, a missing turnaround clock (bus contention with OE), and a strobe of the wrong kind for the request. Sleep is tested twice: once before a request, where a design that ignored it would start early or toggle CE, and once in the middle of a fetch, where a design that did not restart the phase would return a byte captured too early.

// File: rtl/xm_pkg.sv
package xm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_TURN, ST_RD0, ST_RD1, ST_WR, ST_DONE
  } xm_state_e;

  typedef enum logic [1:0] {
    AW_8 = 2'd0, AW_12 = 2'd1, AW_16 = 2'd2, AW_20 = 2'd3
  } xm_awidth_e;

  localparam int ADDR_W  = 20;
  localparam int BYTE_W  = 8;
  localparam int UPPER_W = ADDR_W - 2 * BYTE_W;
endpackage

// File: rtl/xm_phase_timer.sv
module xm_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (restart)       cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/xm_sequencer.sv
module xm_sequencer
  import xm_pkg::*;
#(
  parameter int BYTE_TICKS = 2,
  parameter int CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             sleep,
  input  logic             is_write,
  input  logic             expired,
  output xm_state_e        state,
  output xm_state_e        nxt,
  output logic             restart,
  output logic [CNT_W-1:0] load_val
);
  localparam logic [CNT_W-1:0] PHASE_LAST = CNT_W'(BYTE_TICKS - 1);

  always_comb begin
    nxt = state;
    if (!sleep) begin
      unique case (state)
        ST_IDLE: if (accept)  nxt = ST_ADDR;
        ST_ADDR: if (expired) nxt = is_write ? ST_WR : ST_TURN;
        ST_TURN: if (expired) nxt = ST_RD0;
        ST_RD0:  if (expired) nxt = ST_RD1;
        ST_RD1:  if (expired) nxt = ST_DONE;
        ST_WR:   if (expired) nxt = ST_DONE;
        ST_DONE: nxt = ST_IDLE;
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (nxt)
      ST_ADDR, ST_RD0, ST_RD1, ST_WR: load_val = PHASE_LAST;
      default:                        load_val = '0;
    endcase
  end

  assign restart = sleep || (nxt != state);

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/xm_pin_drive.sv
module xm_pin_drive
  import xm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  xm_state_e           nxt,
  input  logic                sleep,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                is_write,
  input  xm_awidth_e          width,
  output logic [BYTE_W-1:0]   ad_o,
  output logic                ad_oe_o,
  output logic [BYTE_W-1:0]   ahi_o,
  output logic                ahi_oe_o,
  output logic [UPPER_W-1:0]  aup_o,
  output logic                aup_oe_o,
  output logic                ale_o,
  output logic                oe_n_o,
  output logic                wrl_n_o,
  output logic                ce_n_o,
  output logic                ba0_o,
  output logic                done_o
);
  logic               busy, hi_en, up_en;
  logic [BYTE_W-1:0]  ad_d;
  logic               ad_oe_d, ale_d, oe_n_d, wrl_n_d, ba0_d;

  assign busy  = !sleep && (nxt inside {ST_ADDR, ST_TURN, ST_RD0, ST_RD1, ST_WR});
  assign hi_en = busy && (width != AW_8);
  assign up_en = busy && (width == AW_20);

  always_comb begin
    ad_d = '0; ad_oe_d = 1'b0; ale_d = 1'b0;
    oe_n_d = 1'b1; wrl_n_d = 1'b1; ba0_d = 1'b0;
    if (!sleep) begin
      unique case (nxt)
        ST_ADDR: begin
          ale_d = 1'b1; ad_oe_d = 1'b1; ad_d = addr[BYTE_W-1:0];
          ba0_d = is_write & addr[0];
        end
        ST_RD0: oe_n_d = 1'b0;
        ST_RD1: begin oe_n_d = 1'b0; ba0_d = 1'b1; end
        ST_WR: begin
          wrl_n_d = 1'b0; ad_oe_d = 1'b1; ad_d = wdata; ba0_d = addr[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_o <= '0; ad_oe_o <= 1'b0; ahi_o <= '0; ahi_oe_o <= 1'b0;
      aup_o <= '0; aup_oe_o <= 1'b0; ale_o <= 1'b0; oe_n_o <= 1'b1;
      wrl_n_o <= 1'b1; ce_n_o <= 1'b1; ba0_o <= 1'b0; done_o <= 1'b0;
    end else begin
      ad_o     <= ad_d;
      ad_oe_o  <= ad_oe_d;
      ahi_o    <= hi_en ? addr[2*BYTE_W-1:BYTE_W] : '0;
      ahi_oe_o <= hi_en;
      aup_o    <= up_en ? addr[ADDR_W-1:2*BYTE_W] : '0;
      aup_oe_o <= up_en;
      ale_o    <= ale_d;
      oe_n_o   <= oe_n_d;
      wrl_n_o  <= wrl_n_d;
      ce_n_o   <= !busy;
      ba0_o    <= ba0_d;
      done_o   <= !sleep && (nxt == ST_DONE);
    end
  end
endmodule

// File: rtl/xm_word_asm.sv
module xm_word_asm
  import xm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  xm_state_e           state,
  input  logic                expired,
  input  logic                sleep,
  input  logic [BYTE_W-1:0]   ad_i,
  output logic [2*BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] lo_q;
  logic              take;

  assign take = expired && !sleep;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      rdata_o <= '0;
    end else if (take && state == ST_RD0) begin
      lo_q <= ad_i;
    end else if (take && state == ST_RD1) begin
      rdata_o <= {ad_i, lo_q};
    end
  end
endmodule

// File: rtl/xmem_mux8_ctrl.sv
module xmem_mux8_ctrl
  import xm_pkg::*;
#(
  parameter int BYTE_TICKS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_i,
  input  logic                req_wr_i,
  input  logic [19:0]         req_addr_i,
  input  logic [7:0]          req_wdata_i,
  input  logic [1:0]          width_i,
  input  logic                sleep_i,
  output logic [15:0]         rdata_o,
  output logic                done_o,
  output logic [7:0]          ad_o,
  output logic                ad_oe_o,
  input  logic [7:0]          ad_i,
  output logic [7:0]          ahi_o,
  output logic                ahi_oe_o,
  output logic [3:0]          aup_o,
  output logic                aup_oe_o,
  output logic                ale_o,
  output logic                oe_n_o,
  output logic                wrl_n_o,
  output logic                ce_n_o,
  output logic                ba0_o
);
  localparam int CNT_W = (BYTE_TICKS > 1) ? $clog2(BYTE_TICKS) : 1;

  xm_state_e         state, nxt;
  logic              accept, restart, expired;
  logic [CNT_W-1:0]  load_val;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  xm_awidth_e        width_q;

  assign accept = (state == ST_IDLE) && req_i && !sleep_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b0; addr_q <= '0; wdata_q <= '0; width_q <= AW_8;
    end else if (accept) begin
      wr_q    <= req_wr_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      width_q <= xm_awidth_e'(width_i);
    end
  end

  xm_sequencer #(.BYTE_TICKS(BYTE_TICKS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .sleep(sleep_i),
    .is_write(wr_q), .expired(expired), .state(state), .nxt(nxt),
    .restart(restart), .load_val(load_val)
  );

  xm_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .restart(restart), .load_val(load_val),
    .expired(expired)
  );

  xm_pin_drive u_pins (
    .clk(clk), .rst(rst), .nxt(nxt), .sleep(sleep_i),
    .addr(accept ? req_addr_i : addr_q),
    .wdata(accept ? req_wdata_i : wdata_q),
    .is_write(accept ? req_wr_i : wr_q),
    .width(accept ? xm_awidth_e'(width_i) : width_q),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ahi_o(ahi_o), .ahi_oe_o(ahi_oe_o),
    .aup_o(aup_o), .aup_oe_o(aup_oe_o), .ale_o(ale_o), .oe_n_o(oe_n_o),
    .wrl_n_o(wrl_n_o), .ce_n_o(ce_n_o), .ba0_o(ba0_o), .done_o(done_o)
  );

  xm_word_asm u_asm (
    .clk(clk), .rst(rst), .state(state), .expired(expired),
    .sleep(sleep_i), .ad_i(ad_i), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/xmem_mux8_chk.sv
module xmem_mux8_chk (
  input logic clk,
  input logic rst,
  input logic sleep_i,
  input logic done_o,
  input logic ad_oe_o,
  input logic ale_o,
  input logic oe_n_o,
  input logic wrl_n_o,
  input logic ce_n_o,
  input logic ahi_oe_o,
  input logic aup_oe_o
);
  assert_ale_drives_bus_R2: assert property (@(posedge clk) disable iff (rst)
    ale_o |-> (ad_oe_o && !ce_n_o));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_no_contention_R4: assert property (@(posedge clk) disable iff (rst)
    !oe_n_o |-> !ad_oe_o);

  assert_turnaround_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n_o) |-> !$past(ale_o));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n_o && !wrl_n_o));

  assert_upper_nest_R8: assert property (@(posedge clk) disable iff (rst)
    aup_oe_o |-> ahi_oe_o);

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $past(sleep_i) |-> (ce_n_o && oe_n_o && wrl_n_o && !ale_o));
endmodule

bind xmem_mux8_ctrl xmem_mux8_chk u_chk (
  .clk(clk), .rst(rst), .sleep_i(sleep_i), .done_o(done_o),
  .ad_oe_o(ad_oe_o), .ale_o(ale_o), .oe_n_o(oe_n_o), .wrl_n_o(wrl_n_o),
  .ce_n_o(ce_n_o), .ahi_oe_o(ahi_oe_o), .aup_oe_o(aup_oe_o)
);

// File: tb/tb_xmem_mux8_ctrl.sv
`timescale 1ns/1ps
module tb_xmem_mux8_ctrl;
  localparam int T = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req = 1'b0, req_wr = 1'b0, sleep = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ad_i, ad_o, ahi_o;
  logic [1:0]  width = '0;
  logic [15:0] rdata;
  logic done, ad_oe, ahi_oe, aup_oe, ale, oe_n, wrl_n, ce_n, ba0;
  logic [3:0] aup_o;
  logic [7:0] lat = '0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  xmem_mux8_ctrl #(.BYTE_TICKS(T)) dut (
    .clk(clk), .rst(rst), .req_i(req), .req_wr_i(req_wr),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .width_i(width),
    .sleep_i(sleep), .rdata_o(rdata), .done_o(done), .ad_o(ad_o),
    .ad_oe_o(ad_oe), .ad_i(ad_i), .ahi_o(ahi_o), .ahi_oe_o(ahi_oe),
    .aup_o(aup_o), .aup_oe_o(aup_oe), .ale_o(ale), .oe_n_o(oe_n),
    .wrl_n_o(wrl_n), .ce_n_o(ce_n), .ba0_o(ba0)
  );

  function automatic logic [7:0] mem_f(input logic [19:0] a);
    return {a[6:0], a[7]} ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
  endfunction

  function automatic logic [19:0] mask_w(input logic [1:0] m, input logic [19:0] a);
    case (m)
      2'd0:    return {12'h0, a[7:0]};
      2'd3:    return a;
      default: return {4'h0, a[15:0]};
    endcase
  endfunction

  logic [19:0] bus_addr;
  assign bus_addr = {aup_oe ? aup_o : 4'h0, ahi_oe ? ahi_o : 8'h00, lat[7:1], ba0};
  assign ad_i = !oe_n ? mem_f(bus_addr) : 8'h00;
  always @(negedge clk) if (ale) lat <= ad_o;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [1:0] m, input logic [19:0] a,
                         input logic [7:0] d, input bit pre_sleep, input int sleep_at);
    int ale_cnt = 0, oe_cnt = 0, wrl_cnt = 0, n = 0, exp_len;
    logic [7:0] first_ad = '0; logic first_oe_ad = 1'b0, turn_ok = 1'b0;
    logic contention = 1'b0, ce_bad = 1'b0, sleep_bad = 1'b0, hi_s = 1'b0, up_s = 1'b0;
    logic ba0_first = 1'b1, ba0_last = 1'b0, sl = 1'b0;
    logic [19:0] wa = '0; logic [7:0] wd = '0; logic wd_oe = 1'b0;
    logic [19:0] ea;
    exp_len = wr ? 2*T+1 : 3*T+2;
    ea = mask_w(m, a);
    @(negedge clk);
    req_wr = wr; width = m; req_addr = a; req_wdata = d; req = 1'b1;
    if (pre_sleep) begin
      sleep = 1'b1;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (!ce_n || ale || done || !oe_n) sleep_bad = 1'b1;
      end
      chk(!sleep_bad, "R9 quiet while sleeping before request", sleep_bad, 0);
      sleep = 1'b0;
    end
    while (n < 100) begin
      @(negedge clk);
      n++;
      if (sl) begin
        if (!ce_n || !oe_n || ale || !wrl_n) sleep_bad = 1'b1;
      end else if (!done && ce_n) ce_bad = 1'b1;
      if (ale) begin
        if (ale_cnt == 0) begin first_ad = ad_o; first_oe_ad = ad_oe; end
        ale_cnt++; hi_s = ahi_oe; up_s = aup_oe;
      end
      if (!oe_n) begin
        if (oe_cnt == 0) ba0_first = ba0;
        ba0_last = ba0; oe_cnt++;
        if (ad_oe) contention = 1'b1;
      end
      if (!wrl_n) begin wrl_cnt++; wa = bus_addr; wd = ad_o; wd_oe = ad_oe; end
      if (n == T+1 && !wr) turn_ok = !ad_oe && oe_n && !ale;
      if (done) break;
      if (sleep_at != 0 && n == sleep_at) sleep = 1'b1;
      if (sleep_at != 0 && n == sleep_at + 4) sleep = 1'b0;
      sl = sleep;
    end
    req = 1'b0;
    chk(done, "R3 done reached", done, 1);
    if (sleep_at == 0) begin
      chk(n == exp_len, wr ? "R5 done latency" : "R3 done latency", n, exp_len);
      chk(ale_cnt == T, "R2 address phase length", ale_cnt, T);
      chk(first_ad == a[7:0] && first_oe_ad, "R2 low address on bus", first_ad, a[7:0]);
      chk(!ce_bad, "R7 CE held through access", ce_bad, 0);
      chk(hi_s == (m != 2'd0) && up_s == (m == 2'd3), "R8 upper drive by width",
          {hi_s, up_s}, {m != 2'd0, m == 2'd3});
    end else begin
      chk(!sleep_bad, "R10 strobes inactive in mid-access sleep", sleep_bad, 0);
    end
    chk(ce_n, "R7 CE high on done clock", ce_n, 1);
    if (wr) begin
      chk(wa == ea && wd == d && wd_oe, "R5 written address/data", {wa, wd}, {ea, d});
      chk(wrl_cnt == T && oe_cnt == 0, "R6 only WRL in write", {wrl_cnt, oe_cnt}, T << 16);
    end else begin
      logic [15:0] ew;
      ew = {mem_f({ea[19:1], 1'b1}), mem_f({ea[19:1], 1'b0})};
      chk(rdata == ew, sleep_at != 0 ? "R10 word after sleep" : "R3 assembled word", rdata, ew);
      chk(wrl_cnt == 0, "R6 WRL idle in fetch", wrl_cnt, 0);
      if (sleep_at == 0) begin
        chk(oe_cnt == 2*T && !ba0_first && ba0_last, "R3 OE length and BA0 order",
            {oe_cnt, ba0_first, ba0_last}, {2*T, 2'b01});
        chk(turn_ok && !contention, "R4 turnaround, no contention", {turn_ok, contention}, 2'b10);
      end
    end
    @(negedge clk);
    chk(!done, "R3 done lasts one clock", done, 0);
  endtask

  localparam logic [30:0] VEC [10] = '{
    {1'b0, 2'd3, 20'hA5C3E, 8'h00}, {1'b0, 2'd0, 20'hFFF01, 8'h00},
    {1'b0, 2'd1, 20'h01234, 8'h00}, {1'b0, 2'd2, 20'h7BEEF, 8'h00},
    {1'b1, 2'd3, 20'h9A1B3, 8'h5A}, {1'b1, 2'd3, 20'h9A1B2, 8'hC3},
    {1'b1, 2'd0, 20'hF00FF, 8'h01}, {1'b1, 2'd2, 20'h12340, 8'hFE},
    {1'b0, 2'd3, 20'h00000, 8'h00}, {1'b0, 2'd3, 20'hFFFFF, 8'h00}
  };

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ale && oe_n && wrl_n && ce_n && !ad_oe && !done, "R1 state during reset",
        {ale, oe_n, wrl_n, ce_n, ad_oe, done}, 6'b011100);
    rst = 1'b0;
    @(negedge clk);
    chk(!ale && oe_n && wrl_n && ce_n && !ad_oe && !done, "R1 state after reset",
        {ale, oe_n, wrl_n, ce_n, ad_oe, done}, 6'b011100);
    foreach (VEC[i]) run_txn(VEC[i][30], VEC[i][29:28], VEC[i][27:8], VEC[i][7:0], 1'b0, 0);
    run_txn(1'b0, 2'd3, 20'h3C5A7, 8'h00, 1'b1, 0);
    run_txn(1'b1, 2'd1, 20'h0ABCD, 8'h77, 1'b1, 0);
    run_txn(1'b0, 2'd3, 20'h5E6F1, 8'h00, 1'b0, T+3);
    run_txn(1'b0, 2'd2, 20'h0F0F0, 8'h00, 1'b0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule